// File: doc/BRIEF.md
# Nested Interrupt Priority Controller

This block decides which of many interrupt requests the core takes next. Every source has a two-bit priority level, and the block compares it with the current priority level of the running code. Peripheral sources and debug-port sources get their levels from configuration fields. The non-maskable source, the ordinary software interrupt and the low-priority software interrupt have fixed levels. When the block accepts a request, it emits a one-cycle accept strobe with the source's vector number, and it raises the running level so that the new handler is shielded from requests of equal or lower level.

Each accept saves the level that was in force onto a small nesting stack. A handler-return strobe pops that stack and restores the saved level, so handlers can nest several deep. Software can also write the running level directly, and this is how it opens the core to maskable requests after reset. If a request would nest deeper than the stack can hold, the block raises a sticky error flag and accepts nothing more until reset.

Top module: `irq_nest_ctrl`

## Requirements
- R1: Reset puts the running level at 3, clears the error flag and clears the accept strobe. In that state, requests at levels 0 to 2 are not accepted.
- R2: Each peripheral source has a 2-bit field, source j at bits [2j+1:2j] of `per_cfg`. Code 0 disables the source, and codes 1, 2 and 3 select levels 0, 1 and 2. A disabled source is never accepted.
- R3: Each debug source has a 2-bit field, source k at bits [2k+1:2k] of `dbg_cfg`. Code 0 disables the source, and codes 1, 2 and 3 select levels 1, 2 and 3.
- R4: An enabled, requesting source is eligible when its level is greater than or equal to the running level. A level-3 source is therefore always eligible.
- R5: Vector numbers are fixed: 0 is the non-maskable source (level 3), 1 is the software interrupt (level `SWI_LEVEL`, default 1), 2 is the low-priority software interrupt, 3 onwards are the debug sources, and the peripherals follow them. Among eligible sources the highest level wins, and ties go to the lowest vector number.
- R6: The design samples the inputs at a clock edge. At that same edge, an accept raises `acc_valid` for exactly one cycle, with the winner on `acc_vec`. The running level becomes the winner's level plus one, except that a level-3 winner leaves it at 3.
- R7: The low-priority software interrupt is eligible only at running level 0. It loses to any other eligible source, and accepting it leaves the running level unchanged.
- R8: `hdl_ret` pops the nesting stack and restores the level saved by the most recent accept, in last-in first-out order. No accept happens in a cycle where `hdl_ret` is high. A return with an empty stack leaves the level unchanged.
- R9: `lvl_wr` loads `lvl_wr_val` into the running level, and no accept happens in that cycle. If `hdl_ret` with a non-empty stack arrives in the same cycle, the return takes priority.
- R10: The stack holds `STACK_DEPTH` (default 4) saved levels. If an eligible request arrives while the stack is full, it is not accepted and `nest_err` is set. `nest_err` stays set, and blocks every later accept, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nmi_req | input | 1 | Non-maskable request, fixed level 3 |
| sw_req | input | 1 | Software interrupt request, fixed level SWI_LEVEL |
| sw_low_req | input | 1 | Low-priority software interrupt request |
| dbg_cfg | input | 2*N_DBG | Debug source level/disable fields |
| dbg_req | input | N_DBG | Debug source request lines |
| per_cfg | input | 2*N_PERIPH | Peripheral source level/disable fields |
| per_req | input | N_PERIPH | Peripheral source request lines |
| hdl_ret | input | 1 | Handler-return strobe |
| lvl_wr | input | 1 | Running-level write strobe |
| lvl_wr_val | input | 2 | Value for a running-level write |
| acc_valid | output | 1 | One-cycle accept strobe |
| acc_vec | output | $clog2(3+N_DBG+N_PERIPH) | Vector number of the accepted source |
| cur_lvl | output | 2 | Running priority level |
| nest_err | output | 1 | Sticky nesting-overflow flag |

## Verification
The bench targets the following corner cases, each with the failure it would expose:
- **Equal levels.** A request whose level equals the running level must be taken. An off-by-one comparison would let it sit masked.
- **Ties.** When two requests at the same level arrive together, including a debug source against a peripheral, the lower vector must win. A reversed scan would report the other one.
- **Level 3 and the low-priority software interrupt.** Neither may raise the level past 3 or raise it at all, respectively. A plain increment would wrap to 0 or lock out level 0 after the low-priority call.
- **Stack depth and collisions.** The bench nests four deep and then sends one more request. It expects the error flag, no accept, and the saved levels coming back in reverse order. It also checks that a return or a level write in the same cycle as a request suppresses the accept and that a return beats a level write, since a wrong ordering there would corrupt the nesting chain.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;

    typedef logic [1:0] lvl_t;

    localparam lvl_t LVL_TOP = 2'd3;
    localparam int   N_FIXED = 3;

    // one decoded source: active (enabled and requesting), level, low-priority software kind
    typedef struct packed {
        logic act;
        lvl_t lvl;
        logic low;
    } src_t;

    function automatic src_t mk_periph(input logic [1:0] cfg, input logic req);
        src_t s;
        s.act = req && (cfg != 2'd0);
        s.lvl = (cfg == 2'd0) ? 2'd0 : lvl_t'(cfg - 2'd1);
        s.low = 1'b0;
        return s;
    endfunction

    function automatic src_t mk_debug(input logic [1:0] cfg, input logic req);
        src_t s;
        s.act = req && (cfg != 2'd0);
        s.lvl = cfg;
        s.low = 1'b0;
        return s;
    endfunction

    function automatic src_t mk_fixed(input lvl_t lvl, input logic req, input logic low);
        src_t s;
        s.act = req;
        s.lvl = lvl;
        s.low = low;
        return s;
    endfunction

    function automatic logic is_eligible(input src_t s, input lvl_t cur);
        return s.act && (s.lvl >= cur);
    endfunction

    // arbitration rank: the low-priority software source sits below every level
    function automatic logic [2:0] rank_of(input src_t s);
        return s.low ? 3'd0 : ({1'b0, s.lvl} + 3'd1);
    endfunction

    function automatic lvl_t raised(input lvl_t l);
        return (l == LVL_TOP) ? LVL_TOP : lvl_t'(l + 2'd1);
    endfunction

endpackage

// File: rtl/irq_src_map.sv
module irq_src_map
    import irq_nest_pkg::*;
#(
    parameter int   N_DBG     = 2,
    parameter int   N_PERIPH  = 8,
    parameter lvl_t SWI_LEVEL = 2'd1
) (
    input  logic                                   nmi_req,
    input  logic                                   sw_req,
    input  logic                                   sw_low_req,
    input  logic [2*N_DBG-1:0]                     dbg_cfg,
    input  logic [N_DBG-1:0]                       dbg_req,
    input  logic [2*N_PERIPH-1:0]                  per_cfg,
    input  logic [N_PERIPH-1:0]                    per_req,
    output src_t [N_FIXED+N_DBG+N_PERIPH-1:0]      srcs
);

    localparam int DBG_BASE = N_FIXED;
    localparam int PER_BASE = N_FIXED + N_DBG;

    assign srcs[0] = mk_fixed(LVL_TOP,   nmi_req,    1'b0);
    assign srcs[1] = mk_fixed(SWI_LEVEL, sw_req,     1'b0);
    assign srcs[2] = mk_fixed(2'd0,      sw_low_req, 1'b1);

    for (genvar k = 0; k < N_DBG; k++) begin : g_dbg
        assign srcs[DBG_BASE+k] = mk_debug(dbg_cfg[2*k +: 2], dbg_req[k]);
    end

    for (genvar j = 0; j < N_PERIPH; j++) begin : g_per
        assign srcs[PER_BASE+j] = mk_periph(per_cfg[2*j +: 2], per_req[j]);
    end

endmodule

// File: rtl/irq_pick.sv
module irq_pick
    import irq_nest_pkg::*;
#(
    parameter int N_SRC = 13,
    parameter int VW    = $clog2(N_SRC)
) (
    input  logic               clk,
    input  logic               rst,
    input  src_t [N_SRC-1:0]   srcs,
    input  lvl_t               cur,
    output logic               found,
    output logic [VW-1:0]      idx,
    output src_t               win
);

    logic [2:0] best_rank;

    always_comb begin
        found     = 1'b0;
        idx       = '0;
        win       = '0;
        best_rank = 3'd0;
        for (int i = 0; i < N_SRC; i++) begin
            if (is_eligible(srcs[i], cur) && (!found || rank_of(srcs[i]) > best_rank)) begin
                found     = 1'b1;
                idx       = VW'(i);
                win       = srcs[i];
                best_rank = rank_of(srcs[i]);
            end
        end
    end

    // R2
    win_enabled_chk: assert property (@(posedge clk) disable iff (rst)
        found |-> (win.act && win.lvl >= cur));

    // R7
    low_only_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (found && win.low) |-> (cur == 2'd0));

endmodule

// File: rtl/lvl_stack.sv
module lvl_stack
    import irq_nest_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int CW    = $clog2(DEPTH + 1),
    parameter int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  push,
    input  logic  pop,
    input  lvl_t  push_val,
    output lvl_t  top_val,
    output logic  full,
    output logic  empty
);

    localparam logic [CW-1:0] ONE  = CW'(1);
    localparam logic [CW-1:0] LIM  = CW'(DEPTH);

    lvl_t          mem [DEPTH];
    logic [CW-1:0] cnt;

    assign full    = (cnt == LIM);
    assign empty   = (cnt == '0);
    assign top_val = empty ? 2'd0 : mem[PW'(cnt - ONE)];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= 2'd0;
        end else if (push && !full) begin
            mem[PW'(cnt)] <= push_val;
            cnt           <= cnt + ONE;
        end else if (pop && !empty) begin
            cnt <= cnt - ONE;
        end
    end

    // R10
    no_push_when_full_chk: assert property (@(posedge clk) disable iff (rst)
        !(push && full));

    // R8
    pop_shrinks_chk: assert property (@(posedge clk) disable iff (rst)
        (pop && !push && !empty) |=> ((cnt + ONE) == $past(cnt)));

endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
    import irq_nest_pkg::*;
#(
    parameter int   N_DBG       = 2,
    parameter int   N_PERIPH    = 8,
    parameter int   STACK_DEPTH = 4,
    parameter lvl_t SWI_LEVEL   = 2'd1,
    parameter int   N_SRC       = N_FIXED + N_DBG + N_PERIPH,
    parameter int   VW          = $clog2(N_SRC)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   nmi_req,
    input  logic                   sw_req,
    input  logic                   sw_low_req,
    input  logic [2*N_DBG-1:0]     dbg_cfg,
    input  logic [N_DBG-1:0]       dbg_req,
    input  logic [2*N_PERIPH-1:0]  per_cfg,
    input  logic [N_PERIPH-1:0]    per_req,
    input  logic                   hdl_ret,
    input  logic                   lvl_wr,
    input  logic [1:0]             lvl_wr_val,
    output logic                   acc_valid,
    output logic [VW-1:0]          acc_vec,
    output logic [1:0]             cur_lvl,
    output logic                   nest_err
);

    localparam logic [VW-1:0] VEC_LOW = VW'(2);

    src_t [N_SRC-1:0] srcs;
    logic             found;
    logic [VW-1:0]    win_idx;
    src_t             win;

    lvl_t  cur_q, nxt_lvl, top_val;
    logic  acc_q, err_q;
    logic [VW-1:0] vec_q;
    logic  stk_full, stk_empty;
    logic  ret_go, try_acc, take, overflow;

    irq_src_map #(
        .N_DBG(N_DBG), .N_PERIPH(N_PERIPH), .SWI_LEVEL(SWI_LEVEL)
    ) u_map (
        .nmi_req(nmi_req), .sw_req(sw_req), .sw_low_req(sw_low_req),
        .dbg_cfg(dbg_cfg), .dbg_req(dbg_req),
        .per_cfg(per_cfg), .per_req(per_req),
        .srcs(srcs)
    );

    irq_pick #(.N_SRC(N_SRC), .VW(VW)) u_pick (
        .clk(clk), .rst(rst), .srcs(srcs), .cur(cur_q),
        .found(found), .idx(win_idx), .win(win)
    );

    lvl_stack #(.DEPTH(STACK_DEPTH)) u_stack (
        .clk(clk), .rst(rst),
        .push(take), .pop(ret_go), .push_val(cur_q),
        .top_val(top_val), .full(stk_full), .empty(stk_empty)
    );

    always_comb begin
        ret_go   = hdl_ret && !stk_empty;
        try_acc  = found && !hdl_ret && !lvl_wr;
        take     = try_acc && !stk_full && !err_q;
        overflow = try_acc && stk_full;
        nxt_lvl  = cur_q;
        if (ret_go)
            nxt_lvl = top_val;
        else if (lvl_wr)
            nxt_lvl = lvl_wr_val;
        else if (take && !win.low)
            nxt_lvl = raised(win.lvl);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= LVL_TOP;
            acc_q <= 1'b0;
            vec_q <= '0;
            err_q <= 1'b0;
        end else begin
            cur_q <= nxt_lvl;
            acc_q <= take;
            if (take) vec_q <= win_idx;
            if (overflow) err_q <= 1'b1;
        end
    end

    assign acc_valid = acc_q;
    assign acc_vec   = vec_q;
    assign cur_lvl   = cur_q;
    assign nest_err  = err_q;

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (cur_q == LVL_TOP && !acc_q && !err_q));

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        err_q |=> err_q);

    // R10
    err_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        err_q |=> !acc_q);

    // R8
    ret_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        hdl_ret |=> !acc_q);

    // R9
    wr_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        lvl_wr |=> !acc_q);

    // R7
    low_keeps_lvl_chk: assert property (@(posedge clk) disable iff (rst)
        (take && win.low) |=> (acc_q && vec_q == VEC_LOW && cur_q == $past(cur_q)));

    // R6
    acc_never_lowers_chk: assert property (@(posedge clk) disable iff (rst)
        take |=> (cur_q >= $past(cur_q)));

endmodule

// File: tb/irq_nest_ctrl_test.sv
module irq_nest_ctrl_test;

    localparam int CLK_P    = 10;
    localparam int N_DBG    = 2;
    localparam int N_PERIPH = 4;
    localparam int VW       = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic nmi_req = 0, sw_req = 0, sw_low_req = 0;
    logic [2*N_DBG-1:0]    dbg_cfg = '0;
    logic [N_DBG-1:0]      dbg_req = '0;
    logic [2*N_PERIPH-1:0] per_cfg = '0;
    logic [N_PERIPH-1:0]   per_req = '0;
    logic hdl_ret = 0, lvl_wr = 0;
    logic [1:0] lvl_wr_val = '0;
    logic acc_valid;
    logic [VW-1:0] acc_vec;
    logic [1:0] cur_lvl;
    logic nest_err;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    always #(CLK_P/2) clk = ~clk;

    irq_nest_ctrl #(.N_DBG(N_DBG), .N_PERIPH(N_PERIPH), .STACK_DEPTH(4)) uut (
        .clk(clk), .rst(rst), .nmi_req(nmi_req), .sw_req(sw_req), .sw_low_req(sw_low_req),
        .dbg_cfg(dbg_cfg), .dbg_req(dbg_req), .per_cfg(per_cfg), .per_req(per_req),
        .hdl_ret(hdl_ret), .lvl_wr(lvl_wr), .lvl_wr_val(lvl_wr_val),
        .acc_valid(acc_valid), .acc_vec(acc_vec), .cur_lvl(cur_lvl), .nest_err(nest_err)
    );

    typedef struct packed {
        logic [1:0] lvl0;
        logic       nmi;
        logic       swi;
        logic       low;
        logic [3:0] dcfg;
        logic [1:0] dreq;
        logic [7:0] pcfg;
        logic [3:0] preq;
        logic       ev;
        logic [3:0] evec;
        logic [1:0] elvl;
    } row_t;

    // vectors: 0 nmi, 1 swi, 2 low swi, 3-4 debug, 5-8 peripherals
    localparam row_t TBL [14] = '{
        '{2'd0,1'b0,1'b0,1'b0,4'b0000,2'b00,8'b00000001,4'b0001,1'b1,4'd5,2'd1}, // R2 R6 level0
        '{2'd0,1'b0,1'b0,1'b0,4'b0000,2'b00,8'b00110001,4'b0101,1'b1,4'd7,2'd3}, // R5 higher wins
        '{2'd1,1'b0,1'b0,1'b0,4'b0000,2'b00,8'b10001000,4'b1010,1'b1,4'd6,2'd2}, // R5 tie low index
        '{2'd2,1'b0,1'b0,1'b0,4'b0000,2'b00,8'b00001000,4'b0010,1'b0,4'd0,2'd2}, // R4 masked
        '{2'd2,1'b0,1'b0,1'b0,4'b0000,2'b00,8'b00001100,4'b0010,1'b1,4'd6,2'd3}, // R4 equal level
        '{2'd0,1'b0,1'b0,1'b0,4'b0000,2'b00,8'b00000000,4'b0001,1'b0,4'd0,2'd0}, // R2 disabled
        '{2'd3,1'b0,1'b0,1'b0,4'b0011,2'b01,8'b00000000,4'b0000,1'b1,4'd3,2'd3}, // R3 R6 level3 stays 3
        '{2'd0,1'b0,1'b0,1'b0,4'b0100,2'b10,8'b00100000,4'b0100,1'b1,4'd4,2'd2}, // R3 R5 debug tie
        '{2'd3,1'b1,1'b0,1'b0,4'b0011,2'b01,8'b00000000,4'b0000,1'b1,4'd0,2'd3}, // R5 nmi first
        '{2'd1,1'b0,1'b1,1'b0,4'b0000,2'b00,8'b00000010,4'b0001,1'b1,4'd1,2'd2}, // R5 swi level1
        '{2'd0,1'b0,1'b0,1'b1,4'b0000,2'b00,8'b00000000,4'b0000,1'b1,4'd2,2'd0}, // R7 no raise
        '{2'd0,1'b0,1'b0,1'b1,4'b0000,2'b00,8'b01000000,4'b1000,1'b1,4'd8,2'd1}, // R7 loses
        '{2'd1,1'b0,1'b0,1'b1,4'b0000,2'b00,8'b00000000,4'b0000,1'b0,4'd0,2'd1}, // R7 masked
        '{2'd0,1'b0,1'b0,1'b0,4'b1100,2'b10,8'b00110000,4'b0100,1'b1,4'd4,2'd3}  // R3 debug level3
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    task automatic clear_reqs();
        nmi_req = 0; sw_req = 0; sw_low_req = 0; dbg_req = '0; per_req = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; clear_reqs(); hdl_ret = 0; lvl_wr = 0; dbg_cfg = '0; per_cfg = '0;
        @(negedge clk);
        @(negedge clk);
        rst = 0;
    endtask

    task automatic set_lvl(input logic [1:0] v);
        lvl_wr = 1; lvl_wr_val = v;
        @(negedge clk);
        lvl_wr = 0;
    endtask

    task automatic run_row(input row_t r, input int i);
        set_lvl(r.lvl0);
        nmi_req = r.nmi; sw_req = r.swi; sw_low_req = r.low;
        dbg_cfg = r.dcfg; dbg_req = r.dreq; per_cfg = r.pcfg; per_req = r.preq;
        @(negedge clk);
        chk("R2/R3/R4/R5/R6/R7", $sformatf("row %0d accept", i), acc_valid, r.ev);
        if (r.ev) chk("R5/R6", $sformatf("row %0d vector", i), acc_vec, r.evec);
        chk("R6/R7", $sformatf("row %0d level", i), cur_lvl, r.elvl);
        clear_reqs(); dbg_cfg = '0; per_cfg = '0;
        if (r.ev) begin
            hdl_ret = 1;
            @(negedge clk);
            hdl_ret = 0;
            chk("R8", $sformatf("row %0d restore", i), cur_lvl, r.lvl0);
        end
    endtask

    task automatic pulse_and_check(input string req, input int ev, input int evec, input int elvl);
        @(negedge clk);
        clear_reqs();
        chk(req, "accept", acc_valid, ev);
        if (ev != 0) chk(req, "vector", acc_vec, evec);
        chk(req, "level", cur_lvl, elvl);
    endtask

    initial begin
        do_reset();
        // R1 reset state
        chk("R1", "level after reset", cur_lvl, 3);
        chk("R1", "strobe after reset", acc_valid, 0);
        chk("R1", "error after reset", nest_err, 0);
        per_cfg = 8'b00000011; per_req = 4'b0001;
        pulse_and_check("R1", 0, 0, 3);

        do_reset();
        for (int i = 0; i < 14; i++) run_row(TBL[i], i);

        // R10 / R8 nesting chain
        do_reset();
        per_cfg = 8'b00111001; dbg_cfg = 4'b0011;
        set_lvl(2'd0);
        per_req = 4'b0001; pulse_and_check("R8", 1, 5, 1);
        per_req = 4'b0010; pulse_and_check("R8", 1, 6, 2);
        per_req = 4'b0100; pulse_and_check("R8", 1, 7, 3);
        nmi_req = 1;       pulse_and_check("R10", 1, 0, 3);
        dbg_req = 2'b01;   pulse_and_check("R10", 0, 0, 3);
        chk("R10", "error flag", nest_err, 1);
        for (int k = 0; k < 4; k++) begin
            hdl_ret = 1;
            @(negedge clk);
            hdl_ret = 0;
            chk("R8", $sformatf("unwind %0d", k), cur_lvl, 3 - k);
        end
        hdl_ret = 1;
        @(negedge clk);
        hdl_ret = 0;
        chk("R8", "return on empty", cur_lvl, 0);
        per_req = 4'b0100; pulse_and_check("R10", 0, 0, 0);
        chk("R10", "error held", nest_err, 1);

        // R9 collisions
        do_reset();
        per_cfg = 8'b00110001;
        set_lvl(2'd0);
        per_req = 4'b0001; pulse_and_check("R9", 1, 5, 1);
        hdl_ret = 1; lvl_wr = 1; lvl_wr_val = 2'd2; per_req = 4'b0100;
        @(negedge clk);
        hdl_ret = 0; lvl_wr = 1; lvl_wr_val = 2'd1;
        chk("R9", "return beats write", cur_lvl, 0);
        chk("R8", "return blocks accept", acc_valid, 0);
        @(negedge clk);
        lvl_wr = 0;
        chk("R9", "write applied", cur_lvl, 1);
        chk("R9", "write blocks accept", acc_valid, 0);
        pulse_and_check("R9", 1, 7, 3);

        done = 1;
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

endmodule